// File: doc/BRIEF.md
# Framed-Message SPI Master

This block is a single-master SPI engine in which one command produces exactly one chip-select-framed message. Software first fills a byte-wide transmit buffer. It then programs the message length and message kind, and finally writes a command word. The command word carries a go bit, an optional count of leading write-only bytes (up to 15), and the index of the peripheral to select. Chip select cannot be held between commands. A register-then-read exchange therefore goes out as a single command: the leading write-only bytes are followed at once by the read phase, with no gap in chip select.

While the command runs, the engine shifts bytes MSB first on the serial clock. It stores the bytes that count as received into a receive buffer and advances a receive tail counter. When the last bit has been sent it releases chip select and flags completion, which reaches the interrupt line through a mask. The serial clock rate comes from a three-bit selector, and clock polarity and phase can be chosen.

Top module: `msg_spi_master`

## Requirements
- R1: After a synchronous active-low reset, all chip selects are high, `spi_sclk` is 0, `irq` is 0, the status busy bit (bit 2 of register 3) is 0 and the receive tail (register 5) is 0.
- R2: In exchange mode (kind 0 in bits 15:14 of register 0, byte count in bits 6:0), the transmit buffer bytes from index 0 appear on `spi_mosi` MSB first. Each byte sampled from `spi_miso` is stored in order in the receive buffer, and the tail then equals the byte count.
- R3: With a lead count P (bits 7:4 of register 1), the first P transmit-buffer bytes are sent before the message bytes and are never stored. P plus the byte count bytes are clocked. In read-only mode (kind 2) the message bytes are sent as 0x00.
- R4: In write-only mode (kind 1 or 3), `spi_miso` is ignored and the tail stays 0.
- R5: Bits 9:8 of register 1 select the one chip select that goes low. It stays low for the whole message and rises right after the last byte. The busy status bit is 1 throughout that window.
- R6: Bit 3 of register 2 sets the idle clock level. With bit 4 clear, data is sampled on the leading edge; with bit 4 set, it is sampled on the trailing edge.
- R7: Bits 2:0 of register 2 select a half clock period of 2^sel system clocks, and a value of 7 behaves as 6.
- R8: At the end of a message, done (bit 0 of register 3) is set. `irq` is the OR of the status bits ANDed with the mask in register 4. Writing 1s to register 3 clears the matching status bits.
- R9: A command written while busy has no effect on the running message.
- R10: If P plus the byte count exceeds the buffer depth, the byte count is reduced to depth minus P and the error status bit (bit 1 of register 3) is set.
- R11: A command with a total of zero bytes asserts no chip select and sets done at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register or buffer write strobe |
| reg_addr | input | ADDR_W | Address: top bits 00 registers, 01 transmit buffer, 10 receive buffer |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NDEV | Active-low chip selects |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest case to reach is a second command written while a message is still being shifted. It has to land inside the chip-select window, and it has to name a different peripheral and length so that any effect would show. The bench writes the command a few cycles after the first one, while the slow clock keeps chip select low. It then checks at the pins that the other select line never fell and that only the original number of bytes was clocked. The overlength case is reached with a lead count combined with a near-full byte count, which shows both the reduced tail and the error bit.

// File: rtl/msg_spi_pkg.sv
// Shared encodings for the framed-message SPI master.
package msg_spi_pkg;
    typedef enum logic [1:0] {
        MT_XCHG  = 2'b00,
        MT_WRITE = 2'b01,
        MT_READ  = 2'b10,
        MT_WRIT2 = 2'b11
    } msg_kind_e;

    localparam int REG_MSG  = 0;
    localparam int REG_CMD  = 1;
    localparam int REG_CFG  = 2;
    localparam int REG_STAT = 3;
    localparam int REG_MASK = 4;
    localparam int REG_TAIL = 5;
endpackage

// File: rtl/msg_spi_buf.sv
// Byte buffer with one write port and one combinational read port.
// Assumes addresses stay inside DEPTH; contents are not reset.
module msg_spi_buf #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [7:0]       rdata
);
    logic [7:0] mem [DEPTH];

    // store one byte per write strobe
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/msg_spi_shifter.sv
// Shifts one byte MSB first with selectable clock polarity, phase and rate.
// Assumes start is only pulsed while idle; done pulses one cycle after the
// sixteenth clock edge, with rx_byte valid in that cycle.
module msg_spi_shifter #(
    parameter int MAX_SEL = 6,
    localparam int TMR_W = MAX_SEL + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic [2:0] rate_sel,
    input  logic       cpol,
    input  logic       cpha,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       done
);
    logic             active;
    logic [3:0]       edge_q;
    logic [TMR_W-1:0] tmr;
    logic [7:0]       sh;
    logic [7:0]       rsh;
    logic             sclk_q;
    logic [2:0]       sel_eff;
    logic [TMR_W-1:0] lim;
    logic             tick, samp, shift_e;

    assign sel_eff = (rate_sel > 3'(MAX_SEL)) ? 3'(MAX_SEL) : rate_sel;
    assign lim     = TMR_W'((1 << sel_eff) - 1);
    assign tick    = active && (tmr == lim);
    // even edges are leading edges
    assign samp    = cpha ? edge_q[0] : ~edge_q[0];
    assign shift_e = !samp && !(cpha && edge_q == 4'd0);

    // bit timing, shifting and sampling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            edge_q <= '0;
            tmr    <= '0;
            sh     <= '0;
            rsh    <= '0;
            sclk_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active <= 1'b1;
                edge_q <= '0;
                tmr    <= '0;
                sh     <= tx_byte;
                sclk_q <= cpol;
            end else if (tick) begin
                tmr    <= '0;
                sclk_q <= ~sclk_q;
                edge_q <= edge_q + 4'd1;
                if (samp)    rsh <= {rsh[6:0], miso};
                if (shift_e) sh  <= {sh[6:0], 1'b0};
                if (edge_q == 4'd15) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end else if (active) begin
                tmr <= tmr + 1'b1;
            end
        end
    end

    assign sclk    = active ? sclk_q : cpol;
    assign mosi    = sh[7];
    assign rx_byte = rsh;
endmodule

// File: rtl/msg_spi_master.sv
// Framed-message SPI master: register file, buffers and message sequencer.
// One command drives one chip-select window of lead bytes plus message bytes.
// Assumes DEPTH is a power of two of at least 16.
module msg_spi_master
    import msg_spi_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int NDEV  = 4,
    localparam int ADDR_W = $clog2(DEPTH) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NDEV-1:0]   spi_cs_n,
    output logic              irq
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = IDX_W + 1;
    localparam int DEV_W = (NDEV > 1) ? $clog2(NDEV) : 1;

    logic [1:0]       region;
    logic [IDX_W-1:0] widx;
    logic [CNT_W-1:0] msg_cnt_q, total_q, idx_q, tail_q;
    msg_kind_e        kind_q, run_kind_q, kind_now;
    logic [2:0]       rate_q;
    logic             cpol_q, cpha_q, busy_q, st_done_q, st_err_q;
    logic [1:0]       mask_q;
    logic [DEV_W-1:0] dev_q;
    logic [3:0]       pre_q, pre_now;
    logic             cmd_hit, cmd_go, clamp, last, sh_start, byte_done, in_msg, rx_we;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] cnt_go, tot_go, idx_next, sh_idx;
    logic [7:0]       tx_rdata, tx_now, rx_byte, rx_rdata;
    logic             sh_mosi;

    assign region   = reg_addr[ADDR_W-1 -: 2];
    assign widx     = reg_addr[IDX_W-1:0];
    assign cmd_hit  = reg_wr && region == 2'b00 && widx == IDX_W'(REG_CMD) && reg_wdata[0];
    assign cmd_go   = cmd_hit && !busy_q;
    assign sum      = (CNT_W+1)'(reg_wdata[7:4]) + (CNT_W+1)'(msg_cnt_q);
    assign clamp    = sum > (CNT_W+1)'(DEPTH);
    assign cnt_go   = clamp ? CNT_W'(DEPTH) - CNT_W'(reg_wdata[7:4]) : msg_cnt_q;
    assign tot_go   = CNT_W'(reg_wdata[7:4]) + cnt_go;
    assign idx_next = idx_q + 1'b1;
    assign last     = idx_next == total_q;
    assign sh_start = (cmd_go && tot_go != '0) || (byte_done && !last);
    assign sh_idx   = cmd_go ? '0 : idx_next;
    assign pre_now  = cmd_go ? reg_wdata[7:4] : pre_q;
    assign kind_now = cmd_go ? kind_q : run_kind_q;
    assign in_msg   = sh_idx >= CNT_W'(pre_now);
    assign tx_now   = (in_msg && kind_now == MT_READ) ? 8'h00 : tx_rdata;
    assign rx_we    = byte_done && idx_q >= CNT_W'(pre_q) && !run_kind_q[0];

    msg_spi_buf #(.DEPTH(DEPTH)) u_txbuf (
        .clk(clk), .we(reg_wr && region == 2'b01), .waddr(widx),
        .wdata(reg_wdata[7:0]), .raddr(sh_idx[IDX_W-1:0]), .rdata(tx_rdata));

    msg_spi_buf #(.DEPTH(DEPTH)) u_rxbuf (
        .clk(clk), .we(rx_we), .waddr(tail_q[IDX_W-1:0]),
        .wdata(rx_byte), .raddr(widx), .rdata(rx_rdata));

    msg_spi_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(tx_now),
        .rate_sel(rate_q), .cpol(cpol_q), .cpha(cpha_q), .miso(spi_miso),
        .sclk(spi_sclk), .mosi(sh_mosi), .rx_byte(rx_byte), .done(byte_done));

    // configuration registers written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_cnt_q <= '0;
            kind_q    <= MT_XCHG;
            rate_q    <= '0;
            cpol_q    <= 1'b0;
            cpha_q    <= 1'b0;
            mask_q    <= '0;
        end else if (reg_wr && region == 2'b00) begin
            case (int'(widx))
                REG_MSG: begin
                    msg_cnt_q <= reg_wdata[CNT_W-1:0];
                    kind_q    <= msg_kind_e'(reg_wdata[15:14]);
                end
                REG_CFG: begin
                    rate_q <= reg_wdata[2:0];
                    cpol_q <= reg_wdata[3];
                    cpha_q <= reg_wdata[4];
                end
                REG_MASK: mask_q <= reg_wdata[1:0];
                default: ;
            endcase
        end
    end

    // message sequencer: byte index, receive tail and busy window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            dev_q      <= '0;
            pre_q      <= '0;
            run_kind_q <= MT_XCHG;
            total_q    <= '0;
            idx_q      <= '0;
            tail_q     <= '0;
        end else if (cmd_go) begin
            busy_q     <= tot_go != '0;
            dev_q      <= reg_wdata[8 +: DEV_W];
            pre_q      <= reg_wdata[7:4];
            run_kind_q <= kind_q;
            total_q    <= tot_go;
            idx_q      <= '0;
            tail_q     <= '0;
        end else if (byte_done) begin
            if (rx_we) tail_q <= tail_q + 1'b1;
            if (last) busy_q <= 1'b0;
            else      idx_q  <= idx_next;
        end
    end

    // interrupt status: write-one-to-clear, hardware set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_done_q <= 1'b0;
            st_err_q  <= 1'b0;
        end else begin
            if (reg_wr && region == 2'b00 && widx == IDX_W'(REG_STAT)) begin
                if (reg_wdata[0]) st_done_q <= 1'b0;
                if (reg_wdata[1]) st_err_q  <= 1'b0;
            end
            if ((cmd_go && tot_go == '0) || (byte_done && last)) st_done_q <= 1'b1;
            if (cmd_go && clamp) st_err_q <= 1'b1;
        end
    end

    for (genvar g = 0; g < NDEV; g++) begin : g_cs
        assign spi_cs_n[g] = !(busy_q && dev_q == DEV_W'(g));
    end

    assign spi_mosi = sh_mosi && busy_q;
    assign irq      = |({st_err_q, st_done_q} & mask_q);

    // register and receive buffer read mux
    always_comb begin
        reg_rdata = '0;
        if (region == 2'b10) begin
            reg_rdata = {8'h00, rx_rdata};
        end else if (region == 2'b00) begin
            case (int'(widx))
                REG_MSG:  reg_rdata = {kind_q, {(14-CNT_W){1'b0}}, msg_cnt_q};
                REG_CFG:  reg_rdata = {11'd0, cpha_q, cpol_q, rate_q};
                REG_STAT: reg_rdata = {13'd0, busy_q, st_err_q, st_done_q};
                REG_MASK: reg_rdata = {14'd0, mask_q};
                REG_TAIL: reg_rdata = {{(16-CNT_W){1'b0}}, tail_q};
                default:  reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/msg_spi_master_chk.sv
// Protocol checker for msg_spi_master, attached by bind below.
module msg_spi_master_chk #(
    parameter int DEPTH = 64,
    parameter int NDEV  = 4,
    localparam int CNT_W = $clog2(DEPTH) + 1,
    localparam int DEV_W = (NDEV > 1) ? $clog2(NDEV) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NDEV-1:0]  cs_n,
    input logic             sclk,
    input logic             cpol,
    input logic             busy,
    input logic             st_done,
    input logic [1:0]       run_kind,
    input logic [CNT_W-1:0] tail,
    input logic [CNT_W-1:0] total,
    input logic [DEV_W-1:0] dev,
    input logic             cmd_hit
);
    p_one_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);

    p_sclk_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |-> (sclk == cpol));

    p_done_on_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(&cs_n) |-> st_done);

    p_write_no_tail_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_kind[0]) |-> (tail == '0));

    p_cmd_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_hit) |=> ($stable(dev) && $stable(total)));

    p_tail_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tail <= CNT_W'(DEPTH));
endmodule

bind msg_spi_master msg_spi_master_chk #(.DEPTH(DEPTH), .NDEV(NDEV)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk), .cpol(cpol_q),
    .busy(busy_q), .st_done(st_done_q), .run_kind(run_kind_q), .tail(tail_q),
    .total(total_q), .dev(dev_q), .cmd_hit(cmd_hit));

// File: tb/msg_spi_master_tb.sv
module msg_spi_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;
    localparam int NDEV  = 4;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [15:0]       reg_wdata = '0;
    logic [15:0]       reg_rdata;
    logic              spi_sclk, spi_mosi, spi_miso;
    logic [NDEV-1:0]   spi_cs_n;
    logic              irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    msg_spi_master #(.DEPTH(DEPTH), .NDEV(NDEV)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .irq(irq));

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // slave model
    logic            tb_cpha = 1'b0;
    logic            tb_cpol = 1'b0;
    logic            mon_clr = 1'b0;
    logic            sclk_q = 1'b0;
    logic            cs_idle_q = 1'b1;
    logic [7:0]      mon [80];
    int              nbytes = 0;
    int              bitc = 0;
    logic [7:0]      rsh = '0;
    logic [NDEV-1:0] cs_seen = '0;
    int              nedges = 0;
    int              e0 = 0, e1 = 0;

    function automatic logic [7:0] pat(int n);
        return 8'h5A ^ 8'(n * 37);
    endfunction

    assign spi_miso = (&spi_cs_n) ? 1'b0 : pat(nbytes)[7 - bitc];

    always @(posedge clk) begin
        logic lead, trail, samp;
        sclk_q    <= spi_sclk;
        cs_idle_q <= &spi_cs_n;
        if (mon_clr || (cs_idle_q && !(&spi_cs_n))) begin
            nbytes <= 0;
            bitc   <= 0;
            nedges <= 0;
            if (mon_clr) cs_seen <= '0;
            else         cs_seen <= cs_seen | ~spi_cs_n;
        end else if (!(&spi_cs_n)) begin
            cs_seen <= cs_seen | ~spi_cs_n;
            lead  = (sclk_q == tb_cpol) && (spi_sclk != tb_cpol);
            trail = (sclk_q != tb_cpol) && (spi_sclk == tb_cpol);
            samp  = tb_cpha ? trail : lead;
            if (lead || trail) begin
                if (nedges == 0) e0 <= cyc;
                if (nedges == 1) e1 <= cyc;
                nedges <= nedges + 1;
            end
            if (samp) begin
                if (bitc == 7) begin
                    mon[nbytes] <= {rsh[6:0], spi_mosi};
                    nbytes <= nbytes + 1;
                    bitc <= 0;
                end else begin
                    rsh  <= {rsh[6:0], spi_mosi};
                    bitc <= bitc + 1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = 16'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        reg_addr = ADDR_W'(a);
        #1 d = int'(reg_rdata);
    endtask

    task automatic clear_mon();
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4 && (&spi_cs_n); i++) @(negedge clk);
        for (int i = 0; i < 20000 && !(&spi_cs_n); i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic set_cfg(input int sel, input bit cpol, input bit cpha);
        tb_cpol = cpol; tb_cpha = cpha;
        wr(2, sel | (int'(cpol) << 3) | (int'(cpha) << 4));
    endtask

    task automatic t_reset();
        int d;
        check(&spi_cs_n, "R1 cs_n idle", int'(spi_cs_n), 15);
        check(spi_sclk == 1'b0, "R1 sclk", int'(spi_sclk), 0);
        check(irq == 1'b0, "R1 irq", int'(irq), 0);
        rd(3, d); check(d == 0, "R1 status", d, 0);
        rd(5, d); check(d == 0, "R1 tail", d, 0);
    endtask

    task automatic t_exchange(input bit cpol, input bit cpha, input int dev);
        int d;
        clear_mon();
        set_cfg(0, cpol, cpha);
        for (int i = 0; i < 4; i++) wr(8'h40 + i, 8'hC3 ^ (i * 29) ^ (dev << 4));
        wr(0, 4);
        wr(1, 1 | (dev << 8));
        rd(3, d); check(((d >> 2) & 1) == 1, "R5 busy during message", d, 4);
        check(spi_cs_n[dev] == 1'b0, "R5 cs low during message", int'(spi_cs_n), dev);
        wait_idle();
        rd(3, d); check(((d >> 2) & 1) == 0, "R5 busy cleared", d, 0);
        check(cs_seen == NDEV'(1 << dev), "R5 only selected cs", int'(cs_seen), 1 << dev);
        check(nbytes == 4, "R2 bytes clocked", nbytes, 4);
        for (int i = 0; i < 4; i++) begin
            int e = (8'hC3 ^ (i * 29) ^ (dev << 4)) & 255;
            check(mon[i] == 8'(e), "R6 mosi byte", int'(mon[i]), e);
            rd(8'h80 + i, d);
            check(d == int'(pat(i)), "R2 rx byte", d, int'(pat(i)));
        end
        rd(5, d); check(d == 4, "R2 tail", d, 4);
        wr(3, 16'hFFFF);
    endtask

    task automatic t_prepend();
        int d;
        clear_mon();
        set_cfg(0, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) wr(8'h40 + i, 8'h11 * (i + 1));
        wr(0, 2 | (2 << 14));
        wr(1, 1 | (3 << 4) | (1 << 8));
        wait_idle();
        check(nbytes == 5, "R3 lead plus message bytes", nbytes, 5);
        for (int i = 0; i < 3; i++)
            check(mon[i] == 8'(8'h11 * (i + 1)), "R3 lead byte", int'(mon[i]), 8'h11 * (i + 1));
        for (int i = 3; i < 5; i++)
            check(mon[i] == 8'h00, "R3 read phase mosi low", int'(mon[i]), 0);
        rd(5, d); check(d == 2, "R3 tail excludes lead", d, 2);
        for (int i = 0; i < 2; i++) begin
            rd(8'h80 + i, d);
            check(d == int'(pat(3 + i)), "R3 rx after lead", d, int'(pat(3 + i)));
        end
        check(cs_seen == 4'b0010, "R3 single window", int'(cs_seen), 2);
        wr(3, 16'hFFFF);
    endtask

    task automatic t_write_only();
        int d;
        clear_mon();
        wr(0, 3 | (1 << 14));
        wr(1, 1 | (2 << 8));
        wait_idle();
        rd(5, d); check(d == 0, "R4 tail stays zero", d, 0);
        check(nbytes == 3, "R4 bytes clocked", nbytes, 3);
        wr(0, 2 | (3 << 14));
        wr(1, 1);
        wait_idle();
        rd(5, d); check(d == 0, "R4 kind 3 tail zero", d, 0);
        wr(3, 16'hFFFF);
    endtask

    task automatic t_rate(input int sel, input int half);
        clear_mon();
        set_cfg(sel, 1'b0, 1'b0);
        wr(0, 1);
        wr(1, 1);
        wait_idle();
        check(e1 - e0 == half, "R7 half period", e1 - e0, half);
        wr(3, 16'hFFFF);
    endtask

    task automatic t_irq();
        int d;
        set_cfg(0, 1'b0, 1'b0);
        wr(4, 0);
        wr(0, 1);
        wr(1, 1);
        wait_idle();
        rd(3, d); check((d & 1) == 1, "R8 done set", d, 1);
        check(irq == 1'b0, "R8 masked irq", int'(irq), 0);
        wr(4, 1);
        #1 check(irq == 1'b1, "R8 unmasked irq", int'(irq), 1);
        wr(3, 16'hFFFF);
        #1 check(irq == 1'b0, "R8 clear all irq", int'(irq), 0);
        rd(3, d); check(d == 0, "R8 status cleared", d, 0);
        wr(4, 0);
    endtask

    task automatic t_busy_cmd();
        int d;
        clear_mon();
        set_cfg(3, 1'b0, 1'b0);
        wr(0, 2);
        wr(1, 1);
        repeat (4) @(negedge clk);
        wr(0, 6);
        wr(1, 1 | (2 << 8));
        wait_idle();
        check(cs_seen == 4'b0001, "R9 second cs untouched", int'(cs_seen), 1);
        check(nbytes == 2, "R9 length unchanged", nbytes, 2);
        rd(5, d); check(d == 2, "R9 tail", d, 2);
        wr(3, 16'hFFFF);
    endtask

    task automatic t_clamp();
        int d;
        clear_mon();
        set_cfg(0, 1'b0, 1'b0);
        wr(0, 63);
        wr(1, 1 | (4 << 4));
        wait_idle();
        rd(3, d); check(((d >> 1) & 1) == 1, "R10 error bit", d, 2);
        rd(5, d); check(d == 60, "R10 clamped tail", d, 60);
        check(nbytes == 64, "R10 bytes clocked", nbytes, 64);
        rd(8'h80 + 59, d); check(d == int'(pat(63)), "R10 last rx byte", d, int'(pat(63)));
        wr(3, 16'hFFFF);
    endtask

    task automatic t_zero();
        int d;
        clear_mon();
        wr(0, 0);
        wr(1, 1);
        repeat (3) @(negedge clk);
        rd(3, d); check((d & 1) == 1, "R11 done at once", d, 1);
        check(cs_seen == '0, "R11 no cs", int'(cs_seen), 0);
        wr(3, 16'hFFFF);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        for (int m = 0; m < 4; m++) t_exchange(m[1], m[0], m);
        t_prepend();
        t_write_only();
        t_rate(2, 4);
        t_rate(7, 64);
        t_irq();
        t_busy_cmd();
        t_clamp();
        t_zero();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule